// File: doc/BRIEF.md
# Digital PLL Lock Monitor

This block watches the UP and DOWN outputs of a phase-frequency detector and decides whether the loop is locked. A fast measurement clock samples both pulses. In each reference cycle the block counts how many ticks each pulse was high. The phase error for that cycle is the larger of the two counts. A strobe marks the end of each reference cycle, and at that strobe the error is graded against two thresholds.

The lock flag rises only after a run of consecutive clean cycles. An input selects whether that run is short or long. Once the flag is up, it stays up until some later cycle has an error above the wider exit threshold. Errors that fall between the two thresholds are tolerated while locked.

A second output enables the RF output stage. When muting is requested, this enable is held off until lock is declared. The active-low reset input doubles as the power-down control.

The design is a two-state machine:

- **ST_SEEK** counts clean cycles. It takes transition **T_ACQUIRE** to ST_LOCKED when the run reaches the required length. It takes transition **T_RESTART** back to itself, with the run cleared, on any cycle that is not clean.
- **ST_LOCKED** takes transition **T_HOLD** back to itself on any error at or below the exit threshold. It takes transition **T_LOSE** to ST_SEEK on an error above that threshold.

Top module: `pll_lock_monitor`

## Requirements
- R1: `locked` is active high. It reads 0 immediately whenever `rst_n` is low, and it stays 0 after `rst_n` is released until a lock is declared.
- R2: With `prec_sel` = 0, `locked` goes high at the strobe that closes the third consecutive cycle whose error is below ENTER_TICKS (15 ticks by default).
- R3: With `prec_sel` = 1, five such consecutive cycles are needed.
- R4: Before lock, any cycle with an error of ENTER_TICKS or more resets the run of clean cycles to zero.
- R5: While locked, a cycle with an error at or below EXIT_TICKS (25 ticks by default) keeps `locked` high. This includes errors in the band from ENTER_TICKS to EXIT_TICKS.
- R6: While locked, a cycle with an error above EXIT_TICKS clears `locked` at the strobe that closes that cycle. The next lock then needs a complete new run.
- R7: A cycle's error is the larger of the UP and DOWN high-tick counts. The counts include every tick from the one after the previous strobe up to and including the strobe tick. The counts saturate rather than wrap.
- R8: `rf_enable` equals `locked` when `mute_en` = 1, and is 1 when `mute_en` = 0.
- R9: Asserting `rst_n` low in the middle of a run discards the clean cycles already counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock; one period is one tick |
| rst_n | input | 1 | Active-low asynchronous reset and power-down |
| up_pulse | input | 1 | UP output of the phase detector |
| dn_pulse | input | 1 | DOWN output of the phase detector |
| ref_strobe | input | 1 | One-tick pulse on the last tick of each reference cycle |
| prec_sel | input | 1 | 0 selects the short run of 3 cycles, 1 selects the long run of 5 cycles |
| mute_en | input | 1 | 1 holds the RF output enable off until lock |
| locked | output | 1 | Lock flag |
| rf_enable | output | 1 | Enable for the RF output stage |

## Verification
The hardest situation to reach is an error that lands exactly on a threshold edge at the right point in a run. Examples are a 15-tick error arriving just before the last needed clean cycle, or a 25-tick versus 26-tick error while locked. The bench reaches these by sweeping the UP width, and separately the DOWN width, across every value from 0 to past the exit threshold. Each width is applied after a fresh reset and, separately, after a lock has been established. A reference model in the bench grades every reference cycle. Unequal UP and DOWN widths, saturating widths and a mid-run power-down are added as directed cases.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [0:0] {
        ST_SEEK   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    typedef enum logic [1:0] {
        EC_CLEAN  = 2'd0,
        EC_MARGIN = 2'd1,
        EC_GROSS  = 2'd2
    } err_class_t;

endpackage

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
    parameter int WW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse,
    input  logic          close,
    output logic [WW-1:0] width_o
);
    localparam logic [WW-1:0] MAXV = {WW{1'b1}};

    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (close) begin
            cnt_q <= '0;
        end else if (pulse && cnt_q != MAXV) begin
            cnt_q <= cnt_q + WW'(1);
        end
    end

    always_comb begin
        if (cnt_q == MAXV) begin
            width_o = MAXV;
        end else begin
            width_o = cnt_q + WW'(pulse);
        end
    end

    // R7: a fresh cycle starts from zero after the closing strobe
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (width_o <= WW'(1)));

    // R7: the width never drops inside a cycle (saturation, no wrap)
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(close) && !close |-> (width_o >= $past(cnt_q)));

endmodule

// File: rtl/error_grader.sv
module error_grader
    import pll_lock_pkg::*;
#(
    parameter int WW          = 5,
    parameter int ENTER_TICKS = 15,
    parameter int EXIT_TICKS  = 25
) (
    input  logic [WW-1:0] width_a,
    input  logic [WW-1:0] width_b,
    output err_class_t    grade_o
);
    localparam logic [WW-1:0] ENTER_W = WW'(ENTER_TICKS);
    localparam logic [WW-1:0] EXIT_W  = WW'(EXIT_TICKS);

    logic [WW-1:0] err;

    always_comb begin
        err = (width_a > width_b) ? width_a : width_b;
        if (err < ENTER_W) begin
            grade_o = EC_CLEAN;
        end else if (err > EXIT_W) begin
            grade_o = EC_GROSS;
        end else begin
            grade_o = EC_MARGIN;
        end
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import pll_lock_pkg::*;
#(
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       close,
    input  err_class_t grade,
    input  logic       prec_sel,
    input  logic       mute_en,
    output logic       locked,
    output logic       rf_enable
);
    localparam int RUN_W = $clog2(LONG_RUN + 1);

    lock_state_t      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [RUN_W-1:0] need;

    assign need = prec_sel ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (close) begin
            unique case (state_q)
                ST_SEEK: begin
                    if (grade == EC_CLEAN) begin
                        if (run_q + RUN_W'(1) >= need) begin
                            state_d = ST_LOCKED;     // T_ACQUIRE
                            run_d   = '0;
                        end else begin
                            run_d   = run_q + RUN_W'(1);
                        end
                    end else begin
                        run_d = '0;                  // T_RESTART
                    end
                end
                ST_LOCKED: begin
                    if (grade == EC_GROSS) begin
                        state_d = ST_SEEK;           // T_LOSE
                        run_d   = '0;
                    end                              // else T_HOLD
                end
                default: begin
                    state_d = ST_SEEK;
                    run_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        locked    = (state_q == ST_LOCKED);
        rf_enable = locked || !mute_en;
    end

    // R2 / R3: lock is only declared at a strobe that closed a clean cycle
    a_r2_entry_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(close && grade == EC_CLEAN));

    // R4: a non-clean cycle while seeking never declares lock
    a_r4_no_entry_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && close && grade != EC_CLEAN |=> !locked);

    // R5: lock held through clean and margin cycles
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !(close && grade == EC_GROSS) |=> locked);

    // R6: gross error drops lock at the closing strobe
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        locked && close && grade == EC_GROSS |=> !locked);

    // R3: run length never passes the longest selectable run
    a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(LONG_RUN));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import pll_lock_pkg::*;
#(
    parameter int TICK_PS   = 1000,
    parameter int ENTER_PS  = 15000,
    parameter int EXIT_PS   = 25000,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_pulse,
    input  logic dn_pulse,
    input  logic ref_strobe,
    input  logic prec_sel,
    input  logic mute_en,
    output logic locked,
    output logic rf_enable
);
    localparam int ENTER_TICKS = ENTER_PS / TICK_PS;
    localparam int EXIT_TICKS  = EXIT_PS / TICK_PS;
    localparam int WW          = $clog2(EXIT_TICKS + 2);

    logic [NUM_CH-1:0]  pulses;
    logic [WW-1:0]      widths [NUM_CH];
    err_class_t         grade;

    assign pulses = {dn_pulse, up_pulse};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_meter
        pulse_width_meter #(.WW(WW)) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse   (pulses[ch]),
            .close   (ref_strobe),
            .width_o (widths[ch])
        );
    end

    error_grader #(
        .WW          (WW),
        .ENTER_TICKS (ENTER_TICKS),
        .EXIT_TICKS  (EXIT_TICKS)
    ) u_grader (
        .width_a (widths[0]),
        .width_b (widths[1]),
        .grade_o (grade)
    );

    lock_fsm #(
        .SHORT_RUN (SHORT_RUN),
        .LONG_RUN  (LONG_RUN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .close     (ref_strobe),
        .grade     (grade),
        .prec_sel  (prec_sel),
        .mute_en   (mute_en),
        .locked    (locked),
        .rf_enable (rf_enable)
    );

    // R8: muted output stays off until lock
    a_r8_mute: assert property (@(posedge clk) disable iff (!rst_n)
        mute_en && !locked |-> !rf_enable);

    // R1: flag low in the cycle after a reset release
    a_r1_reset_low: assert property (@(posedge clk)
        !$past(rst_n) |-> !locked);

endmodule

// File: tb/pll_lock_monitor_test.sv
`timescale 1ns/1ps
module pll_lock_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_LEN    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_pulse = 1'b0, dn_pulse = 1'b0, ref_strobe = 1'b0;
    logic prec_sel = 1'b0, mute_en = 1'b1;
    logic locked, rf_enable;

    int errors = 0;
    int checks = 0;
    int m_run = 0;
    bit m_lk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_lock_monitor uut (
        .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
        .ref_strobe(ref_strobe), .prec_sel(prec_sel), .mute_en(mute_en),
        .locked(locked), .rf_enable(rf_enable)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_run = 0;
        m_lk  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One reference cycle; pulses cover the first ticks, strobe on the last.
    task automatic ref_cycle(input int up_w, input int dn_w, input int len, input string tag);
        int err;
        int need;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            up_pulse   = (i < up_w);
            dn_pulse   = (i < dn_w);
            ref_strobe = (i == len - 1);
        end
        @(negedge clk);
        up_pulse = 1'b0; dn_pulse = 1'b0; ref_strobe = 1'b0;
        err  = (up_w > dn_w) ? up_w : dn_w;
        need = prec_sel ? 5 : 3;
        if (m_lk) begin
            if (err > 25) begin m_lk = 1'b0; m_run = 0; end
        end else if (err < 15) begin
            m_run++;
            if (m_run >= need) begin m_lk = 1'b1; m_run = 0; end
        end else begin
            m_run = 0;
        end
        chk(tag, locked, m_lk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        chk("R1 flag low in reset", locked, 1'b0);
        chk("R8 muted enable off in reset", rf_enable, 1'b0);
        do_reset();
        chk("R1 flag low after release", locked, 1'b0);

        // R2 / R3 / R4 / R7: entry sweep over UP then DOWN widths
        for (int p = 0; p < 2; p++) begin
            for (int side = 0; side < 2; side++) begin
                for (int w = 0; w <= 30; w++) begin
                    prec_sel = p[0];
                    do_reset();
                    for (int k = 0; k < 6; k++) begin
                        if (side == 0) ref_cycle(w, 0, CYC_LEN, p ? "R3 entry sweep" : "R2 entry sweep");
                        else           ref_cycle(0, w, CYC_LEN, "R7 entry sweep dn");
                    end
                end
            end
        end

        // R5 / R6: exit sweep from a held lock
        prec_sel = 1'b0;
        for (int side = 0; side < 2; side++) begin
            for (int w = 0; w <= 35; w++) begin
                do_reset();
                repeat (3) ref_cycle(0, 0, CYC_LEN, "R2 prelock");
                if (side == 0) ref_cycle(w, 0, CYC_LEN, w > 25 ? "R6 exit sweep" : "R5 hold sweep");
                else           ref_cycle(0, w, CYC_LEN, w > 25 ? "R6 exit sweep dn" : "R5 hold sweep dn");
                ref_cycle(3, 2, CYC_LEN, "R6 relock needs full run");
            end
        end

        // R4: error just before final clean cycle restarts run
        do_reset();
        ref_cycle(2, 0, CYC_LEN, "R4 clean 1");
        ref_cycle(0, 1, CYC_LEN, "R4 clean 2");
        ref_cycle(15, 0, CYC_LEN, "R4 edge error");
        ref_cycle(0, 0, CYC_LEN, "R4 after restart 1");
        ref_cycle(0, 0, CYC_LEN, "R4 after restart 2");
        ref_cycle(14, 0, CYC_LEN, "R4 third clean");
        chk("R4 locked after new run", locked, 1'b1);

        // R7: max of unequal widths, strobe tick counted, saturation
        do_reset();
        repeat (3) ref_cycle(10, 20, CYC_LEN, "R7 max of up/dn");
        chk("R7 unequal widths keep unlocked", locked, 1'b0);
        repeat (3) ref_cycle(14, 14, 14, "R7 strobe tick counted");
        repeat (3) ref_cycle(0, 0, CYC_LEN, "R7 lock");
        ref_cycle(100, 0, 120, "R7 saturated width drops");
        chk("R6 saturated drop", locked, 1'b0);

        // R9: power-down mid-run discards progress
        do_reset();
        ref_cycle(0, 0, CYC_LEN, "R9 clean 1");
        ref_cycle(0, 0, CYC_LEN, "R9 clean 2");
        do_reset();
        ref_cycle(0, 0, CYC_LEN, "R9 after power-down");
        chk("R9 progress discarded", locked, 1'b0);

        // R8: RF enable in both lock states and mute settings
        mute_en = 1'b1;
        chk("R8 muted unlocked", rf_enable, 1'b0);
        mute_en = 1'b0; #1;
        chk("R8 unmuted unlocked", rf_enable, 1'b1);
        mute_en = 1'b1;
        ref_cycle(0, 0, CYC_LEN, "R9 run 2");
        ref_cycle(0, 0, CYC_LEN, "R9 run 3");
        chk("R8 muted locked", rf_enable, 1'b1);

        // R1: asynchronous clear while locked
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 immediate clear", locked, 1'b0);
        m_lk = 1'b0; m_run = 0;
        @(negedge clk);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule